// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up/Down Counter

This block is the counting core of a general-purpose timer. It holds a 16-bit counter that moves by one step up or down each time a timer-clock enable pulse arrives. A 3-bit clock-select field gates that pulse, and the value zero in the field stops the counter. A CPU with an 8-bit data bus reads and writes the counter. One shared high-byte holding register makes every 16-bit transfer atomic. Reading the low byte captures the upper byte into the holding register in the same cycle. Writing the low byte moves the holding register and the bus byte into the counter together.

Software reads the counter by reading the low byte and then the high byte. It writes the counter by writing the high byte and then the low byte. The bus takes one access per cycle and has no wait states, so there is no back-pressure.

The count enable, direction and clear inputs act only on a gated timer tick. A CPU load of the counter wins over any tick action in the same cycle. The flag outputs report zero, equality with a programmable limit, and an up-count wrap.

Top module: `tmr16_core`

## Requirements
- R1: Synchronous active-high reset sets the counter and the holding register to 0, so both byte reads return 0x00.
- R2: A write with `bus_addr`=1 (high byte) loads only the holding register and leaves the counter unchanged.
- R3: A read with `bus_addr`=0 (low byte) returns counter bits 7:0 combinationally. At that clock edge it copies counter bits 15:8 into the holding register.
- R4: A write with `bus_addr`=0 loads the counter with {holding register, `bus_wdata`} in one edge.
- R5: On a gated tick with `cnt_en`=1, `dir_down`=0 and `clr`=0, the counter increases by exactly 1.
- R6: On a gated tick with `cnt_en`=1, `dir_down`=1 and `clr`=0, the counter decreases by exactly 1.
- R7: On a gated tick with `clr`=1, the counter becomes 0, even when `cnt_en`=1.
- R8: With `clk_sel`=0, ticks are ignored and the counter holds its value, while bus reads and writes still work.
- R9: A low-byte write in the same cycle as a gated tick with clear or count loads the bus value, and the tick has no effect.
- R10: `at_bottom` is 1 exactly when the counter is 0.
- R11: `at_top` is 1 exactly when the counter equals `top_val`.
- R12: `ovf_req` goes high for one cycle, in the cycle after the edge where an up-count takes the counter from 0xFFFF to 0x0000. A down-count wrap does not raise it.
- R13: A read with `bus_addr`=1 returns the holding register and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Clock-select field; 0 stops the timer tick |
| tick | input | 1 | One-cycle timer-clock enable pulse |
| cnt_en | input | 1 | Step the counter on a gated tick |
| dir_down | input | 1 | 1 = decrement, 0 = increment |
| clr | input | 1 | Zero the counter on a gated tick |
| top_val | input | 16 | Programmable maximum compared for `at_top` |
| bus_en | input | 1 | CPU access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = low byte, 1 = high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| at_top | output | 1 | Counter equals `top_val` |
| at_bottom | output | 1 | Counter equals zero |
| ovf_req | output | 1 | One-cycle overflow request on an up-count wrap |

## Verification
A wrong counter value is visible at the ports in the cycle after the bad edge. It shows on `at_bottom` or `at_top`, and on the next low-byte read. A holding register that fails to capture, or that a stray high-byte read or write corrupts, appears only when software reads the high byte next. It also appears as a wrong upper byte after the next low-byte write. The directed sequences therefore always pair a capture with a later high-byte read. A misplaced wrap pulse is exposed by sampling `ovf_req` in each of the two cycles around the 0xFFFF edge.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;

  typedef enum logic [1:0] {
    OP_HOLD,
    OP_LOAD,
    OP_CLEAR,
    OP_STEP
  } cnt_op_e;
endpackage

// File: rtl/tmr_tick_gate.sv
module tmr_tick_gate #(
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             tick,
  output logic             tick_g
);
  localparam logic [SEL_W-1:0] SEL_OFF = '0;
  assign tick_g = tick && (clk_sel != SEL_OFF);
endmodule

// File: rtl/tmr_byte_port.sv
module tmr_byte_port
  import tmr16_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              load_en,
  output logic [CNT_W-1:0]  load_val
);
  logic [BYTE_W-1:0] hold_q;
  logic rd_lo, wr_hi;

  assign rd_lo    = bus_en && !bus_we && (bus_addr == SEL_LO);
  assign wr_hi    = bus_en &&  bus_we && (bus_addr == SEL_HI);
  assign load_en  = bus_en &&  bus_we && (bus_addr == SEL_LO);
  assign load_val = {hold_q, bus_wdata};

  always_ff @(posedge clk) begin
    if (rst)        hold_q <= '0;
    else if (wr_hi) hold_q <= bus_wdata;
    else if (rd_lo) hold_q <= cnt[CNT_W-1:BYTE_W];
  end

  always_comb begin
    if (bus_en && !bus_we && bus_addr == SEL_HI) bus_rdata = hold_q;
    else if (rd_lo)                              bus_rdata = cnt[BYTE_W-1:0];
    else                                         bus_rdata = '0;
  end

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> hold_q == $past(cnt[CNT_W-1:BYTE_W]));
  assert_hi_read_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && bus_addr == SEL_HI) |=> $stable(hold_q));
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick_g,
  input  logic             cnt_en,
  input  logic             dir_down,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_req
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cnt_op_e op;
  logic [CNT_W-1:0] cnt_d;
  logic wrap_up;

  always_comb begin
    if (load_en)              op = OP_LOAD;
    else if (tick_g && clr)   op = OP_CLEAR;
    else if (tick_g && cnt_en) op = OP_STEP;
    else                      op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_LOAD:  cnt_d = load_val;
      OP_CLEAR: cnt_d = '0;
      OP_STEP:  cnt_d = dir_down ? cnt - ONE : cnt + ONE;
      default:  cnt_d = cnt;
    endcase
  end

  assign wrap_up = (op == OP_STEP) && !dir_down && (cnt == ALL_ONES);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ovf_req <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      ovf_req <= wrap_up;
    end
  end

  assert_cpu_wins_R9: assert property (@(posedge clk) disable iff (rst)
    load_en |=> cnt == $past(load_val));
  assert_step_up_R5: assert property (@(posedge clk) disable iff (rst)
    (tick_g && cnt_en && !clr && !dir_down && !load_en) |=> cnt == $past(cnt) + ONE);
  assert_step_down_R6: assert property (@(posedge clk) disable iff (rst)
    (tick_g && cnt_en && !clr && dir_down && !load_en) |=> cnt == $past(cnt) - ONE);
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (tick_g && clr && !load_en) |=> cnt == '0);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!tick_g && !load_en) |=> $stable(cnt));
  assert_ovf_source_R12: assert property (@(posedge clk) disable iff (rst)
    ovf_req |-> (cnt == '0) && ($past(cnt) == ALL_ONES));
endmodule

// File: rtl/tmr_flag_detect.sv
module tmr_flag_detect #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] top_val,
  output logic             at_top,
  output logic             at_bottom
);
  assign at_bottom = (cnt == '0);
  assign at_top    = (cnt == top_val);
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic              tick,
  input  logic              cnt_en,
  input  logic              dir_down,
  input  logic              clr,
  input  logic [CNT_W-1:0]  top_val,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              at_top,
  output logic              at_bottom,
  output logic              ovf_req
);
  logic             tick_g;
  logic             load_en;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;

  tmr_tick_gate #(.SEL_W(SEL_W)) u_gate (
    .clk_sel(clk_sel), .tick(tick), .tick_g(tick_g)
  );

  tmr_byte_port #(.BYTE_W(BYTE_W)) u_port (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt),
    .bus_rdata(bus_rdata), .load_en(load_en), .load_val(load_val)
  );

  tmr_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .tick_g(tick_g), .cnt_en(cnt_en), .dir_down(dir_down), .clr(clr),
    .cnt(cnt), .ovf_req(ovf_req)
  );

  tmr_flag_detect #(.CNT_W(CNT_W)) u_flags (
    .cnt(cnt), .top_val(top_val), .at_top(at_top), .at_bottom(at_bottom)
  );

  assert_stopped_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == '0 && !(bus_en && bus_we && !bus_addr)) |=> $stable(cnt));
  assert_hi_write_only_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr && !tick_g) |=> $stable(cnt));
endmodule

// File: tb/tmr16_core_bench.sv
module tmr16_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]  clk_sel = 3'd0;
  logic        tick = 1'b0, cnt_en = 1'b0, dir_down = 1'b0, clr = 1'b0;
  logic [15:0] top_val = 16'hFFFF;
  logic        bus_en = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        at_top, at_bottom, ovf_req;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tmr16_core u_tmr16_core (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .tick(tick), .cnt_en(cnt_en),
    .dir_down(dir_down), .clr(clr), .top_val(top_val), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .at_top(at_top), .at_bottom(at_bottom),
    .ovf_req(ovf_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic addr, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic addr, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = addr;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic write16(input logic [15:0] v);
    bus_write(1'b1, v[15:8]);
    bus_write(1'b0, v[7:0]);
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_read(1'b0, lo);
    bus_read(1'b1, hi);
    v = {hi, lo};
  endtask

  task automatic pulse_tick(output logic ovf_after);
    @(negedge clk);
    tick = 1'b1;
    @(posedge clk);
    #1 ovf_after = ovf_req;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R10 bottom after reset", at_bottom, 1);
    check("R12 no ovf after reset", ovf_req, 0);
    read16(v);
    check("R1 counter after reset", v, 16'h0000);
  endtask

  task automatic t_high_byte;
    logic [7:0] d;
    bus_write(1'b1, 8'h12);
    check("R2 counter untouched by high write", at_bottom, 1);
    bus_read(1'b1, d);
    check("R13 high read returns holding", d, 8'h12);
    bus_read(1'b1, d);
    check("R13 second high read unchanged", d, 8'h12);
    bus_read(1'b0, d);
    check("R2 low byte still zero", d, 8'h00);
  endtask

  task automatic t_load_capture;
    logic [15:0] v;
    logic [7:0] d;
    write16(16'h1234);
    read16(v);
    check("R4 atomic load", v, 16'h1234);
    bus_write(1'b1, 8'h77);
    bus_read(1'b0, d);
    check("R3 low read data", d, 8'h34);
    bus_read(1'b1, d);
    check("R3 high captured on low read", d, 8'h12);
  endtask

  task automatic t_count;
    logic [15:0] v;
    logic o;
    clk_sel = 3'd3; cnt_en = 1'b1; dir_down = 1'b0;
    for (int i = 0; i < 3; i++) pulse_tick(o);
    read16(v);
    check("R5 up by three", v, 16'h1237);
    dir_down = 1'b1;
    for (int i = 0; i < 2; i++) pulse_tick(o);
    read16(v);
    check("R6 down by two", v, 16'h1235);
  endtask

  task automatic t_stopped;
    logic [15:0] v;
    logic o;
    clk_sel = 3'd0; dir_down = 1'b0;
    for (int i = 0; i < 3; i++) pulse_tick(o);
    read16(v);
    check("R8 held while stopped", v, 16'h1235);
    write16(16'h0005);
    read16(v);
    check("R8 bus works while stopped", v, 16'h0005);
  endtask

  task automatic t_clear;
    logic [15:0] v;
    logic o;
    clk_sel = 3'd1; clr = 1'b1; cnt_en = 1'b1;
    pulse_tick(o);
    clr = 1'b0;
    check("R10 bottom after clear", at_bottom, 1);
    read16(v);
    check("R7 clear beats count", v, 16'h0000);
  endtask

  task automatic t_top;
    logic o;
    top_val = 16'h0003; dir_down = 1'b0;
    for (int i = 0; i < 2; i++) pulse_tick(o);
    check("R11 not top at 2", at_top, 0);
    check("R10 not bottom at 2", at_bottom, 0);
    pulse_tick(o);
    check("R11 top at 3", at_top, 1);
    pulse_tick(o);
    check("R11 past top at 4", at_top, 0);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    logic o;
    write16(16'hFFFE);
    pulse_tick(o);
    check("R12 no ovf at FFFF", o, 0);
    pulse_tick(o);
    check("R12 ovf on wrap", o, 1);
    @(posedge clk); #1;
    check("R12 ovf lasts one cycle", ovf_req, 0);
    check("R10 bottom after wrap", at_bottom, 1);
    dir_down = 1'b1;
    pulse_tick(o);
    check("R12 no ovf on down wrap", o, 0);
    read16(v);
    check("R6 down wrap value", v, 16'hFFFF);
  endtask

  task automatic t_priority;
    logic [15:0] v;
    bus_write(1'b1, 8'hAA);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h55;
    tick = 1'b1; clr = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; tick = 1'b0; clr = 1'b0;
    read16(v);
    check("R9 write beats clear", v, 16'hAA55);
    bus_write(1'b1, 8'h01);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h10;
    tick = 1'b1; dir_down = 1'b0;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; tick = 1'b0;
    read16(v);
    check("R9 write beats count", v, 16'h0110);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_high_byte();
    t_load_capture();
    t_count();
    t_stopped();
    t_clear();
    t_top();
    t_wrap();
    t_priority();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule